// File: doc/BRIEF.md
# Missing-Tooth Wheel Pattern Generator

This block produces the signal a crankshaft sensor would give when it faces a toothed wheel with one tooth removed. A position counter walks around a one-bit-wide pattern store and wraps at the end of the revolution. The stored bit at the current position drives the output pin. A programmable prescaler sets the time spent at each position, so the host sets the emulated engine speed by writing a single period value.

The reset pattern models a 36-1 wheel. There are two positions per tooth pitch, 72 positions in all. A host processor can start and stop the wheel, change the period while the wheel turns, and rewrite any pattern bit to model other wheels. The number of positions is a parameter and reaches 3600 for 0.1 degree steps. The current position index is visible on a port so that other logic can align to the wheel angle.

Top module: `wheel_pattern_gen`

## Requirements
- R1: After reset, `pos_idx` is 0, `wheel_out` is 0, the generator is stopped, the period is `RESET_PERIOD` and the pattern store holds the default wheel.
- R2: Position p of the default pattern is 1 exactly when p is even and p differs from POS_COUNT-2. With 72 positions, read from position 0 upward, this is the 72-bit value AAAA_AAAA_AAAA_AAAA_A8 (hex) taken most significant bit first. That gives 35 teeth and one gap, and the gap shows as three zeros at positions 69, 70 and 71.
- R3: The position only ever moves up by one or wraps from POS_COUNT-1 to 0, and it never leaves the range 0..POS_COUNT-1.
- R4: While running with period P, the position advances once every P+1 clock cycles. P = 0 advances it on every cycle, and the tick counter returns to 0 on each step.
- R5: A period write made while the wheel runs leaves the current step at its full old length and applies from the next step on. While the wheel is stopped, a written period is adopted directly.
- R6: While the enable bit is 0, the position and the tick counter hold and `wheel_out` is 0.
- R7: A pattern write of bit b to index k sets the bit that `wheel_out` shows whenever `pos_idx` equals k. Writes to indexes at or above POS_COUNT change nothing.
- R8: Register writes take effect when `reg_we` is 1 at a rising clock edge. If `reg_addr[ADDR_W]` is 1, the write goes to pattern index `reg_addr[ADDR_W-1:0]` with data `reg_wdata[0]`. If it is 0 and the lower bits equal 0, `reg_wdata` is the period. If it is 0 and the lower bits equal 1, `reg_wdata[0]` is the enable bit. Every other address is ignored.
- R9: POS_COUNT is a parameter. With 3600 positions the same default rule gives teeth on even positions, zeros at 3597..3599, and a wrap after 3599.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W+1 | Register select and pattern index |
| reg_wdata | input | PERIOD_W | Write data |
| wheel_out | output | 1 | Emulated sensor output |
| pos_idx | output | ADDR_W | Current wheel position |

## Verification
The bound checker watches four things on every cycle: the position stays in range, it only steps by one or wraps to zero, it moves only on a prescaler step, and a step returns the tick counter to zero. It also checks that a stopped wheel neither moves nor drives its output. The value of each pattern bit cannot be seen by those properties, so the bench scenarios cover it: the default 36-1 layout, the exact count of cycles per step for a given period, a period change that lands mid-step, pattern rewrites and ignored addresses, and the 3600-position wheel.

// File: rtl/wpg_pkg.sv
package wpg_pkg;

  // Lower-address selectors for the control registers (address MSB = 0)
  localparam logic SEL_PERIOD = 1'b0;
  localparam logic SEL_ENABLE = 1'b1;

  // Default wheel: a tooth on every even position, last tooth slot empty
  function automatic logic tooth_present(int unsigned p, int unsigned len);
    return ((p % 2) == 0) && (p != (len - 2));
  endfunction

endpackage

// File: rtl/wpg_regs.sv
module wpg_regs #(
  parameter int          ADDR_W       = 7,
  parameter int          PERIOD_W     = 24,
  parameter int unsigned RESET_PERIOD = 1000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_we,
  input  logic [ADDR_W:0]     reg_addr,
  input  logic [PERIOD_W-1:0] reg_wdata,
  output logic [PERIOD_W-1:0] period_q,
  output logic                enable_q,
  output logic                pat_we,
  output logic [ADDR_W-1:0]   pat_addr,
  output logic                pat_bit
);
  import wpg_pkg::*;

  logic                ctrl_space;
  logic                period_we;
  logic                enable_we;
  logic [PERIOD_W-1:0] period_d;
  logic                enable_d;

  always_comb begin
    ctrl_space = reg_we && !reg_addr[ADDR_W] && (reg_addr[ADDR_W-1:1] == '0);
    period_we  = ctrl_space && (reg_addr[0] == SEL_PERIOD);
    enable_we  = ctrl_space && (reg_addr[0] == SEL_ENABLE);
    pat_we     = reg_we && reg_addr[ADDR_W];
    pat_addr   = reg_addr[ADDR_W-1:0];
    pat_bit    = reg_wdata[0];
    period_d   = period_we ? reg_wdata : period_q;
    enable_d   = enable_we ? reg_wdata[0] : enable_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      period_q <= PERIOD_W'(RESET_PERIOD);
      enable_q <= 1'b0;
    end else begin
      period_q <= period_d;
      enable_q <= enable_d;
    end
  end

endmodule

// File: rtl/wpg_prescaler.sv
module wpg_prescaler #(
  parameter int          PERIOD_W     = 24,
  parameter int unsigned RESET_PERIOD = 1000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic [PERIOD_W-1:0] period_in,
  output logic                step,
  output logic [PERIOD_W-1:0] tick
);

  logic [PERIOD_W-1:0] tick_q, tick_d;
  logic [PERIOD_W-1:0] act_q, act_d;

  // Active period is only reloaded at a step boundary or while stopped
  always_comb begin
    step   = run && (tick_q >= act_q);
    tick_d = tick_q;
    act_d  = act_q;
    if (!run) begin
      act_d = period_in;
    end else if (step) begin
      tick_d = '0;
      act_d  = period_in;
    end else begin
      tick_d = tick_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= '0;
      act_q  <= PERIOD_W'(RESET_PERIOD);
    end else begin
      tick_q <= tick_d;
      act_q  <= act_d;
    end
  end

  assign tick = tick_q;

endmodule

// File: rtl/wpg_position.sv
module wpg_position #(
  parameter int POS_COUNT = 72,
  localparam int ADDR_W   = $clog2(POS_COUNT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  output logic [ADDR_W-1:0] pos
);

  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(POS_COUNT - 1);

  logic [ADDR_W-1:0] pos_q, pos_d;

  always_comb begin
    pos_d = pos_q;
    if (step) begin
      pos_d = (pos_q == LAST) ? '0 : pos_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= '0;
    else        pos_q <= pos_d;
  end

  assign pos = pos_q;

endmodule

// File: rtl/wpg_pattern_mem.sv
module wpg_pattern_mem #(
  parameter int POS_COUNT = 72,
  localparam int ADDR_W   = $clog2(POS_COUNT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wr_bit,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_bit
);

  logic bits_q [POS_COUNT];

  for (genvar g = 0; g < POS_COUNT; g++) begin : g_cell
    localparam logic DEF_BIT = wpg_pkg::tooth_present(g, POS_COUNT);
    logic cell_en;
    assign cell_en = wr_en && (wr_addr == ADDR_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       bits_q[g] <= DEF_BIT;
      else if (cell_en) bits_q[g] <= wr_bit;
    end
  end

  assign rd_bit = bits_q[rd_addr];

endmodule

// File: rtl/wheel_pattern_gen.sv
module wheel_pattern_gen #(
  parameter int          POS_COUNT    = 72,
  parameter int          PERIOD_W     = 24,
  parameter int unsigned RESET_PERIOD = 1000,
  localparam int         ADDR_W       = $clog2(POS_COUNT)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_we,
  input  logic [ADDR_W:0]     reg_addr,
  input  logic [PERIOD_W-1:0] reg_wdata,
  output logic                wheel_out,
  output logic [ADDR_W-1:0]   pos_idx
);

  logic [1:0]          rst_pipe_q;
  logic                rst_core_n;
  logic [PERIOD_W-1:0] period_q;
  logic                enable_q;
  logic                pat_we;
  logic [ADDR_W-1:0]   pat_addr;
  logic                pat_bit;
  logic                step;
  logic [PERIOD_W-1:0] tick_cnt;
  logic                pat_rd_bit;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[1];

  wpg_regs #(
    .ADDR_W(ADDR_W), .PERIOD_W(PERIOD_W), .RESET_PERIOD(RESET_PERIOD)
  ) u_regs (
    .clk(clk), .rst_n(rst_core_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .period_q(period_q), .enable_q(enable_q),
    .pat_we(pat_we), .pat_addr(pat_addr), .pat_bit(pat_bit)
  );

  wpg_prescaler #(
    .PERIOD_W(PERIOD_W), .RESET_PERIOD(RESET_PERIOD)
  ) u_pre (
    .clk(clk), .rst_n(rst_core_n), .run(enable_q), .period_in(period_q),
    .step(step), .tick(tick_cnt)
  );

  wpg_position #(.POS_COUNT(POS_COUNT)) u_pos (
    .clk(clk), .rst_n(rst_core_n), .step(step), .pos(pos_idx)
  );

  wpg_pattern_mem #(.POS_COUNT(POS_COUNT)) u_mem (
    .clk(clk), .rst_n(rst_core_n), .wr_en(pat_we), .wr_addr(pat_addr),
    .wr_bit(pat_bit), .rd_addr(pos_idx), .rd_bit(pat_rd_bit)
  );

  assign wheel_out = enable_q & pat_rd_bit;

endmodule

// File: rtl/wpg_checker.sv
module wpg_checker #(
  parameter int POS_COUNT = 72,
  parameter int PERIOD_W  = 24,
  localparam int ADDR_W   = $clog2(POS_COUNT)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                run,
  input logic                step,
  input logic [PERIOD_W-1:0] tick,
  input logic [ADDR_W-1:0]   pos,
  input logic                wheel_out
);

  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(POS_COUNT - 1);

  assert_pos_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pos <= LAST);

  assert_pos_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pos) |-> ((pos == $past(pos) + 1'b1) || (($past(pos) == LAST) && (pos == '0))));

  assert_move_only_on_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(pos));

  assert_step_clears_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (tick == '0));

  assert_stopped_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> ($stable(pos) && $stable(tick)));

  assert_stopped_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !wheel_out);

endmodule

bind wheel_pattern_gen wpg_checker #(
  .POS_COUNT(POS_COUNT), .PERIOD_W(PERIOD_W)
) u_chk (
  .clk(clk), .rst_n(rst_core_n), .run(enable_q), .step(step),
  .tick(tick_cnt), .pos(pos_idx), .wheel_out(wheel_out)
);

// File: tb/wheel_pattern_gen_tb_top.sv
module wheel_pattern_gen_tb_top;

  localparam int BIG_COUNT = 3600;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [23:0] reg_wdata = '0;
  logic        wheel_out;
  logic [6:0]  pos_idx;

  logic        big_we = 1'b0;
  logic [12:0] big_addr = '0;
  logic [23:0] big_wdata = '0;
  logic        big_out;
  logic [11:0] big_pos;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  localparam logic [71:0] DEF_WHEEL = 72'hAAAA_AAAA_AAAA_AAAA_A8;

  always #4 clk = ~clk;

  wheel_pattern_gen dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .wheel_out(wheel_out), .pos_idx(pos_idx)
  );

  wheel_pattern_gen #(.POS_COUNT(BIG_COUNT)) dut_big_i (
    .clk(clk), .rst_n(rst_n), .reg_we(big_we), .reg_addr(big_addr),
    .reg_wdata(big_wdata), .wheel_out(big_out), .pos_idx(big_pos)
  );

  task automatic check(string req, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int def_bit(int p);
    return int'(DEF_WHEEL[71 - p]);
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] a, int d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = 24'(d);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic wr_big(logic [12:0] a, int d);
    big_we = 1'b1; big_addr = a; big_wdata = 24'(d);
    @(negedge clk);
    big_we = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1", "reset pos", int'(pos_idx), 0);
    check("R1", "reset out", int'(wheel_out), 0);
    repeat (20) @(negedge clk);
    check("R1", "stopped after reset pos", int'(pos_idx), 0);
  endtask

  task automatic t_default_pattern();
    do_reset();
    wr(8'h00, 0);
    wr(8'h01, 1);
    for (int n = 0; n < 80; n++) begin
      check("R3", "pos P=0", int'(pos_idx), n % 72);
      check("R2", "default bit", int'(wheel_out), def_bit(n % 72));
      @(negedge clk);
    end
  endtask

  task automatic t_period();
    do_reset();
    wr(8'h00, 3);
    wr(8'h02, 0);  // R8: unused control address, must not touch period
    wr(8'h01, 1);
    for (int n = 0; n < 40; n++) begin
      check("R4", "pos P=3 (R8 ignored addr)", int'(pos_idx), (n / 4) % 72);
      @(negedge clk);
    end
  endtask

  task automatic t_period_change();
    do_reset();
    wr(8'h00, 5);
    wr(8'h01, 1);
    @(negedge clk);
    wr(8'h00, 1);
    for (int k = 1; k <= 10; k++) begin
      @(negedge clk);
      check("R5", "pos after mid-step write", int'(pos_idx),
            (k < 4) ? 0 : 1 + (k - 4) / 2);
    end
  endtask

  task automatic t_stop();
    int p0;
    do_reset();
    wr(8'h00, 0);
    wr(8'h01, 1);
    repeat (5) @(negedge clk);
    wr(8'h01, 0);
    p0 = int'(pos_idx);
    check("R6", "pos at stop", p0, 6);
    for (int n = 0; n < 10; n++) begin
      @(negedge clk);
      check("R6", "held pos", int'(pos_idx), p0);
      check("R6", "out low stopped", int'(wheel_out), 0);
    end
    wr(8'h01, 1);
    check("R6", "pos on restart", int'(pos_idx), p0);
    @(negedge clk);
    check("R6", "pos resumes", int'(pos_idx), p0 + 1);
  endtask

  task automatic t_pattern_write();
    do_reset();
    wr(8'h00, 0);
    wr({1'b1, 7'd1}, 1);
    wr({1'b1, 7'd4}, 0);
    wr({1'b1, 7'd70}, 1);
    wr({1'b1, 7'd100}, 0);  // beyond wheel length: ignored
    wr(8'h01, 1);
    for (int n = 0; n < 72; n++) begin
      int e;
      e = def_bit(n);
      if (n == 1 || n == 70) e = 1;
      if (n == 4) e = 0;
      check("R7", "rewritten pattern", int'(wheel_out), e);
      @(negedge clk);
    end
    check("R7", "wrapped pos", int'(pos_idx), 0);
    wr({1'b1, 7'd1}, 0);
    check("R7", "pos at live rewrite", int'(pos_idx), 1);
    check("R7", "live rewrite value", int'(wheel_out), 0);
  endtask

  task automatic t_long_wheel();
    do_reset();
    wr_big(13'h0000, 0);
    wr_big(13'h0001, 1);
    for (int n = 0; n < BIG_COUNT + 4; n++) begin
      int p;
      p = n % BIG_COUNT;
      check("R9", "long pos", int'(big_pos), p);
      check("R9", "long bit", int'(big_out),
            ((p % 2 == 0) && p < BIG_COUNT - 2) ? 1 : 0);
      @(negedge clk);
    end
  endtask

  initial begin
    t_reset();
    t_default_pattern();
    t_period();
    t_period_change();
    t_stop();
    t_pattern_write();
    t_long_wheel();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog all-requirements actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

endmodule